// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps a wall-clock time of day as three byte registers (seconds, minutes, hours) and advances it once per second. The second is derived from a 32768 Hz tick input through a binary prescaler of `DIV_W` bits, so one second is 2^DIV_W ticks. The byte registers are held either as two packed decimal digits (tens in the upper nibble) or as plain binary, and the hour is shown in either 24-hour form or 12-hour form with a PM flag in bit 7.

Each time the seconds advance, the block raises a one-cycle update-ended pulse. In the same cycle it raises an alarm pulse if the new time equals all three alarm bytes, where any alarm byte with both top bits set matches every value. A software-visible update-in-progress level warns, ahead of each seconds update, that the time is about to change. Counting can be halted by a hold (SET) input or by the divider-control field. Releasing a divider reset restarts the prescaler at its midpoint, so the first update comes half a second later.

Register writes go through one byte-wide port with a 3-bit select. Mode bits, hold and divider control are plain inputs.

Top module: `tod_alarm_counter`

## Requirements
- R1: After reset the seconds, minutes, hours and the three alarm bytes are 0x00, `uf`, `af`, `uip` and `upd_ie` are 0, and the prescaler sits at its midpoint 2^(DIV_W-1).
- R2: With `set_hold`=0 and `div_ctl` at most 3'b010, the time advances exactly once every 2^DIV_W ticks. With `div_ctl` above 3'b010 or with `set_hold`=1, the time does not advance and no `uf` pulse occurs.
- R3: While `div_ctl[2:1]`=2'b11 (divider reset) the prescaler is held at its midpoint. After release to a running setting, the first update comes 2^(DIV_W-1) ticks later.
- R4: `uip` is 1 exactly when the counter runs (as in R2) and the prescaler is within the last `UIP_TICKS` ticks before an update. It returns to 0 in the cycle the update lands, and it is 0 throughout divider reset.
- R5: In packed-decimal mode (`bin_mode`=0) seconds and minutes count 0x00..0x59 with a carry from the units digit into the tens digit (0x09 to 0x10), and 0x59 wraps to 0x00 with a carry into the next field.
- R6: In binary mode (`bin_mode`=1) the bytes hold plain values 0..59 (hours 0..23 in 24-hour form), with the same wrap and carry points as R5.
- R7: In 24-hour mode (`hr24`=1) the hour counts 0..23 and wraps 23 to 0 when minutes and seconds wrap.
- R8: In 12-hour mode (`hr24`=0) the hour byte holds 1..12 in its low 7 bits, with bit 7 set for PM. Midnight reads as 12 AM, 11 AM advances to 12 PM (0x92 in packed-decimal mode), 12 PM advances to 1 PM, and 11 PM advances to 12 AM.
- R9: Each update produces a `uf` pulse exactly one cycle wide, in the cycle the new time first appears on the outputs.
- R10: `af` pulses together with `uf` when each alarm byte either equals the new time byte or has bits 7:6 = 2'b11 (wildcard). Otherwise `af` stays 0.
- R11: While `set_hold`=1, `upd_ie` is forced to 0 and ignores writes. Time writes take effect, and after `set_hold` falls counting continues from the written values.
- R12: A write with `wr_en`=1 stores `wr_data` by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours, 6 sets `upd_ie` from bit 0. Select 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the 32768 Hz rate |
| set_hold | input | 1 | Freezes the time while 1 |
| div_ctl | input | 3 | Divider control: at most 010 runs, 11x holds the prescaler in reset |
| bin_mode | input | 1 | 1 binary bytes, 0 packed-decimal bytes |
| hr24 | input | 1 | 1 for 24-hour hours, 0 for 12-hour hours with PM in bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| uip | output | 1 | Update-in-progress level |
| uf | output | 1 | Update-ended pulse |
| af | output | 1 | Alarm pulse |
| upd_ie | output | 1 | Update-ended interrupt enable |

## Verification
The hardest thing to reach from the ports is every hour transition in all four format combinations, above all the 12-hour AM/PM crossings. Plain counting would need a simulated day for each one. The bench instead holds the counter with `set_hold`, writes hh:59:59 for each of the 24 hours in each mode, releases the hold and checks the single following update against a time computed arithmetically. The half-second release after divider reset is checked by counting clock cycles from release to the first `uf` pulse and counting the `uip` cycles before it.

// File: rtl/tod_alarm_counter.sv
module tod_alarm_counter #(
  parameter int DIV_W     = 15,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       set_hold,
  input  logic [2:0] div_ctl,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       uip,
  output logic       uf,
  output logic       af,
  output logic       upd_ie
);
  localparam logic [DIV_W-1:0] DIV_TOP  = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(1) << (DIV_W - 1);
  localparam logic [DIV_W-1:0] UIP_FROM = DIV_TOP - DIV_W'(UIP_TICKS - 1);

  logic [DIV_W-1:0] div_q;
  logic [7:0] al_sec, al_min, al_hour;

  wire osc_ok  = (div_ctl <= 3'b010);
  wire div_rst = (div_ctl[2:1] == 2'b11);
  wire running = osc_ok && !set_hold;
  wire step    = tick && running && (div_q == DIV_TOP);

  function automatic logic [6:0] to_bin(input logic [7:0] b, input logic raw);
    return raw ? b[6:0] : 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] from_bin(input logic [6:0] v, input logic raw);
    return raw ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic fld_hit(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  wire [6:0] s_cur  = to_bin(sec_o, bin_mode);
  wire [6:0] m_cur  = to_bin(min_o, bin_mode);
  wire [6:0] h_raw  = to_bin({1'b0, hour_o[6:0]}, bin_mode);
  wire [6:0] h_cur  = hr24 ? h_raw : (h_raw % 7'd12) + (hour_o[7] ? 7'd12 : 7'd0);

  wire       s_wrap = (s_cur >= 7'd59);
  wire       m_wrap = (m_cur >= 7'd59);
  wire [6:0] s_nx   = s_wrap ? 7'd0 : s_cur + 7'd1;
  wire [6:0] m_nx   = s_wrap ? (m_wrap ? 7'd0 : m_cur + 7'd1) : m_cur;
  wire [6:0] h_nx   = (s_wrap && m_wrap) ? ((h_cur >= 7'd23) ? 7'd0 : h_cur + 7'd1) : h_cur;
  wire [6:0] h_mod  = h_nx % 7'd12;
  wire [6:0] h_12   = (h_mod == 7'd0) ? 7'd12 : h_mod;

  wire [7:0] sec_nx_b  = from_bin(s_nx, bin_mode);
  wire [7:0] min_nx_b  = from_bin(m_nx, bin_mode);
  wire [7:0] hour_nx_b = hr24 ? from_bin(h_nx, bin_mode)
                              : (from_bin(h_12, bin_mode) | {h_nx >= 7'd12, 7'd0});

  wire alarm_hit = fld_hit(al_sec, sec_nx_b) && fld_hit(al_min, min_nx_b) &&
                   fld_hit(al_hour, hour_nx_b);

  assign uip = running && (div_q >= UIP_FROM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_MID;
      sec_o   <= 8'h00;
      min_o   <= 8'h00;
      hour_o  <= 8'h00;
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      uf      <= 1'b0;
      af      <= 1'b0;
      upd_ie  <= 1'b0;
    end else begin
      uf <= step;
      af <= step && alarm_hit;
      if (div_rst)
        div_q <= DIV_MID;
      else if (tick && osc_ok)
        div_q <= div_q + DIV_W'(1);
      if (step) begin
        sec_o  <= sec_nx_b;
        min_o  <= min_nx_b;
        hour_o <= hour_nx_b;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: sec_o   <= wr_data;
          3'd1: min_o   <= wr_data;
          3'd2: hour_o  <= wr_data;
          3'd3: al_sec  <= wr_data;
          3'd4: al_min  <= wr_data;
          3'd5: al_hour <= wr_data;
          default: ;
        endcase
      end
      if (set_hold)
        upd_ie <= 1'b0;
      else if (wr_en && wr_sel == 3'd6)
        upd_ie <= wr_data[0];
    end
  end

  assert_uf_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> $past(!set_hold && div_ctl <= 3'b010));

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf && !$past(wr_en)) |-> $stable(sec_o));

  assert_uip_off_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |-> !uip);

  assert_uf_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> !uf);

  assert_af_with_uf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    af |-> uf);

  assert_ie_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> !upd_ie);
endmodule

// File: tb/sim_tod_alarm_counter.sv
`timescale 1ns/100ps
module sim_tod_alarm_counter;
  localparam int DW = 5;
  localparam int PER = 1 << DW;
  localparam int HALF = PER / 2;
  localparam int UT = 8;

  logic clk = 0, rst_n = 0, tick = 1, set_hold = 0, bin_mode = 0, hr24 = 1, wr_en = 0;
  logic [2:0] div_ctl = 3'b110, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] sec_o, min_o, hour_o;
  logic uip, uf, af, upd_ie;

  int errs = 0, checks = 0, cyc = 0, uip_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tod_alarm_counter #(.DIV_W(DW), .UIP_TICKS(UT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_hold(set_hold), .div_ctl(div_ctl),
    .bin_mode(bin_mode), .hr24(hr24), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .uip(uip), .uf(uf), .af(af),
    .upd_ie(upd_ie));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errs++;
      $display("FAIL watchdog: act=%0d exp<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int enc(input int v, input bit raw);
    return raw ? v : ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int ench(input int h, input bit raw, input bit h24);
    int h12;
    if (h24) return enc(h, raw);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, raw) | ((h >= 12) ? 8'h80 : 0);
  endfunction

  task automatic wr(input int sel, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_uf(output int n);
    n = 0; uip_seen = 0;
    do begin
      @(negedge clk);
      n++;
      if (uip) uip_seen++;
    end while (!uf && n < 200);
  endtask

  task automatic load_time(input int h, input int m, input int s);
    @(negedge clk); set_hold = 1;
    wr(0, enc(s, bin_mode));
    wr(1, enc(m, bin_mode));
    wr(2, ench(h, bin_mode, hr24));
    @(negedge clk); set_hold = 0;
  endtask

  initial begin
    int n, t, hx, exp_s, exp_m, exp_h;
    repeat (3) @(negedge clk);
    chk(sec_o == 0 && min_o == 0 && hour_o == 0, "R1 time regs", {sec_o, min_o, hour_o}, 0);
    chk(!uf && !af && !uip && !upd_ie, "R1 flags", {uf, af, uip, upd_ie}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(sec_o == 0 && !uf && !uip, "R1 held in divider reset", {sec_o, uf, uip}, 0);

    // R3: release divider reset, first update after half a period
    div_ctl = 3'b010;
    wait_uf(n);
    chk(n == HALF, "R3 half-second release", n, HALF);
    chk(uip_seen == UT, "R4 uip window length", uip_seen, UT);
    chk(sec_o == 8'h01 && min_o == 0 && hour_o == 0, "R2 first advance", sec_o, 8'h01);
    @(negedge clk);
    chk(!uf, "R9 uf one cycle", uf, 0);
    chk(!uip, "R4 uip clear after update", uip, 0);
    wait_uf(n);
    chk(n == PER - 1, "R2 period", n + 1, PER);

    // R2: halted divider settings
    div_ctl = 3'b100;
    n = 0;
    repeat (3 * PER) begin @(negedge clk); if (uf || uip) n++; end
    chk(n == 0 && sec_o == 8'h02, "R2 halted by div_ctl", sec_o, 8'h02);
    div_ctl = 3'b010;

    // R11/R12: hold behaviour and interrupt enable
    @(negedge clk); set_hold = 1;
    wr(6, 1);
    chk(!upd_ie, "R11 ie forced low under hold", upd_ie, 0);
    n = 0;
    repeat (3 * PER) begin @(negedge clk); if (uf) n++; end
    chk(n == 0 && sec_o == 8'h02, "R11 time frozen", sec_o, 8'h02);
    wr(7, 8'h55);
    chk(sec_o == 8'h02 && min_o == 0 && hour_o == 0, "R12 select 7 no effect", sec_o, 8'h02);
    @(negedge clk); set_hold = 0;
    wr(6, 1);
    chk(upd_ie, "R12 ie write", upd_ie, 1);
    @(negedge clk); set_hold = 1;
    @(negedge clk);
    chk(!upd_ie, "R11 hold clears ie", upd_ie, 0);
    set_hold = 0;

    // R5..R8: every hour transition in each format
    for (int md = 0; md < 4; md++) begin
      bin_mode = md[0]; hr24 = md[1];
      for (int h = 0; h < 24; h++) begin
        load_time(h, 59, 59);
        wait_uf(n);
        hx = (h + 1) % 24;
        chk(sec_o == enc(0, bin_mode), bin_mode ? "R6 sec wrap" : "R5 sec wrap", sec_o, 0);
        chk(min_o == enc(0, bin_mode), bin_mode ? "R6 min wrap" : "R5 min wrap", min_o, 0);
        chk(hour_o == 8'(ench(hx, bin_mode, hr24)), hr24 ? "R7 hour step" : "R8 hour step",
            hour_o, ench(hx, bin_mode, hr24));
      end
    end

    // R5/R10: contiguous run in packed-decimal 24h with a wildcarded alarm
    bin_mode = 0; hr24 = 1;
    wr(3, 8'h30); wr(4, 8'hC0); wr(5, 8'hC5);
    load_time(9, 58, 50);
    t = 9 * 3600 + 58 * 60 + 50;
    for (int k = 0; k < 80; k++) begin
      wait_uf(n);
      if (k > 0) chk(n == PER, "R2 steady period", n, PER);
      t++;
      exp_s = enc(t % 60, 0); exp_m = enc((t / 60) % 60, 0); exp_h = enc(t / 3600, 0);
      chk(sec_o == 8'(exp_s) && min_o == 8'(exp_m) && hour_o == 8'(exp_h), "R5 decimal count",
          {hour_o, min_o, sec_o}, (exp_h << 16) | (exp_m << 8) | exp_s);
      chk(af == (exp_s == 8'h30), "R10 wildcard alarm", af, exp_s == 8'h30);
    end

    // R10: exact alarm, then mismatch in one field
    wr(3, 8'h05); wr(4, 8'h00); wr(5, 8'h10);
    load_time(10, 0, 3);
    wait_uf(n);
    chk(!af && sec_o == 8'h04, "R10 no match yet", af, 0);
    wait_uf(n);
    chk(af && sec_o == 8'h05, "R10 full match", af, 1);
    wr(4, 8'h01);
    load_time(10, 0, 4);
    wait_uf(n);
    chk(!af, "R10 minute mismatch", af, 0);

    // R8: 12h alarm with PM hour byte
    hr24 = 0;
    wr(3, 8'hC0); wr(4, 8'h00); wr(5, 8'h81);
    load_time(13, 0, 10);
    wait_uf(n);
    chk(af && hour_o == 8'h81, "R8 PM alarm byte", hour_o, 8'h81);

    // R3/R4: divider reset mid-count, uip low, then release
    div_ctl = 3'b111;
    n = 0;
    repeat (2 * PER) begin @(negedge clk); if (uip || uf) n++; end
    chk(n == 0, "R4 uip low in divider reset", n, 0);
    div_ctl = 3'b001;
    wait_uf(n);
    chk(n == HALF, "R3 second release", n, HALF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule